// File: doc/BRIEF.md
# Parallel Bus Master Controller

This block drives an external 16-bit slave device over a parallel bus. A host reaches it through a small register port. The host pushes write data into an eight-word transmit queue. It starts read bursts through a control register and collects the returned words from an eight-word receive queue. Every bus cycle is timed by an internal cycle tick. The tick is the system clock divided by an integer. Each cycle asserts a combined clock/chip-select strobe for one tick period and releases it for the next. Write and read direction strobes stay asserted across the whole cycle.

Writes and reads share the bus without either one cutting into the other. Queued write data goes out in back-to-back cycles for as long as the transmit queue holds words. A requested read burst is held back until that queue has drained. A burst that has started runs to its end before any further write begins. The read-request bit drops by itself once the burst finishes.

Register map (two-bit address): 0 is control, 1 is the transmit push, 2 is the receive pop, 3 is status.

Top module: `pbm_ctrl`

## Requirements
- R1: After reset the status word (address 3) reads 0x14, meaning transmit empty and receive empty with all other flags clear. The strobes `bus_cs`, `bus_wr`, `bus_rd` and `bus_req` are all low. Status bits are: [0] busy, [1] tx full, [2] tx empty, [3] rx full, [4] rx empty, [5] read pending.
- R2: The transmit queue holds 8 words. A push to address 1 while the queue is full is dropped and never appears on the bus. Status bit [1] reads 1 while the queue is full.
- R3: A cycle with divider value d (control bits [11:8]) holds `bus_cs` high for d+1 system clocks and then low for d+1 clocks. `bus_wr` is high across both halves of a write cycle. `bus_dout` stays stable for the whole cycle, and words leave in push order.
- R4: While the transmit queue holds data, write cycles follow one another with no idle clock. n queued words with divider d therefore keep `bus_req` high for exactly n·2·(d+1) clocks.
- R5: A read burst that is requested while the transmit queue holds data does not start until every queued word has been written.
- R6: A burst reads count+1 words, where count is control bits [3:1]. Each word is sampled from `bus_din` when `bus_cs` falls during a read cycle and is queued for popping at address 2 in arrival order.
- R7: After a burst starts, words pushed during it are written only after its final read cycle.
- R8: Writing 1 to control bit [0] sets the read-pending flag. Writing 0 has no effect on it. The flag reads 1 until the burst completes and then clears by itself.
- R9: The count and divider values are captured when a burst starts. Control writes made during the burst change neither its length nor its timing.
- R10: The receive queue holds 8 words. A word arriving while it is full is dropped. A pop of an empty queue has no effect, and status bit [3] reads 1 while the queue is full.
- R11: `bus_req` and status busy are high during every cycle, write or read, and low when the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 2 | Register select |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (pops at address 2) |
| host_wdata | input | 16 | Register write data |
| host_rdata | output | 16 | Register read data for `host_addr` |
| bus_cs | output | 1 | Combined clock/chip-select strobe |
| bus_wr | output | 1 | Write cycle in progress |
| bus_rd | output | 1 | Read cycle in progress |
| bus_req | output | 1 | Cycle indicator, high during any write or read cycle |
| bus_oe | output | 1 | Data drive enable toward the slave |
| bus_dout | output | 16 | Write data to the slave |
| bus_din | input | 16 | Read data from the slave |

## Verification
On every cycle the assertions check strobe consistency: reads and writes are exclusive, `bus_cs` only appears inside a cycle, and write data holds through the released half. They also check that a read only starts with the transmit queue empty and that the pending flag only drops at the end of a read. The bench scenarios are what show the counts and orderings: burst lengths of count+1, the exact number of chained write clocks, dropped words at both queues, and deferral of writes pushed mid-burst. They also show that mid-burst control changes are ignored.

// File: rtl/pbm_ctrl.sv
module pbm_ctrl #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int CNT_W = 3,
  parameter int DIV_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    host_addr,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          bus_cs,
  output logic          bus_wr,
  output logic          bus_rd,
  output logic          bus_req,
  output logic          bus_oe,
  output logic [DW-1:0] bus_dout,
  input  logic [DW-1:0] bus_din
);
  localparam int AW = $clog2(DEPTH);

  typedef enum logic [2:0] {S_IDLE, S_WA, S_WB, S_RA, S_RB} st_t;
  st_t st, nxt;

  logic             rd_pend;
  logic [CNT_W-1:0] cnt_cfg, left;
  logic [DIV_W-1:0] div_cfg, div_q, divcnt;
  logic [DW-1:0]    dout_q;
  logic [DW-1:0]    tx_mem [DEPTH];
  logic [DW-1:0]    rx_mem [DEPTH];
  logic [AW:0]      tx_wp, tx_rp, rx_wp, rx_rp;

  wire tx_empty = tx_wp == tx_rp;
  wire tx_full  = (tx_wp[AW] != tx_rp[AW]) && (tx_wp[AW-1:0] == tx_rp[AW-1:0]);
  wire rx_empty = rx_wp == rx_rp;
  wire rx_full  = (rx_wp[AW] != rx_rp[AW]) && (rx_wp[AW-1:0] == rx_rp[AW-1:0]);

  wire ctrl_we  = host_wr && host_addr == 2'd0;
  wire tx_push  = host_wr && host_addr == 2'd1 && !tx_full;
  wire rx_pop   = host_rd && host_addr == 2'd2 && !rx_empty;

  wire tick       = divcnt == div_q;
  wire burst_done = tick && st == S_RB && left == '0;
  wire launch     = st == S_IDLE || (tick && st == S_WB) || burst_done;
  wire start_wr   = launch && !tx_empty;
  wire start_rd   = launch && tx_empty && rd_pend && !burst_done;
  wire rx_push    = tick && st == S_RA && !rx_full;

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE: if (start_wr) nxt = S_WA; else if (start_rd) nxt = S_RA;
      S_WA:   if (tick) nxt = S_WB;
      S_RA:   if (tick) nxt = S_RB;
      default:
        if (tick) begin
          if (st == S_RB && left != '0) nxt = S_RA;
          else if (start_wr)            nxt = S_WA;
          else if (start_rd)            nxt = S_RA;
          else                          nxt = S_IDLE;
        end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      rd_pend <= 1'b0;
      cnt_cfg <= '0;
      div_cfg <= '0;
      div_q   <= '0;
      divcnt  <= '0;
      left    <= '0;
      dout_q  <= '0;
      tx_wp   <= '0;
      tx_rp   <= '0;
      rx_wp   <= '0;
      rx_rp   <= '0;
    end else begin
      st     <= nxt;
      divcnt <= (launch || tick) ? '0 : divcnt + 1'b1;
      if (ctrl_we) begin
        cnt_cfg <= host_wdata[1 +: CNT_W];
        div_cfg <= host_wdata[8 +: DIV_W];
      end
      if (ctrl_we && host_wdata[0]) rd_pend <= 1'b1;
      else if (burst_done)          rd_pend <= 1'b0;
      if (start_wr || start_rd) div_q <= div_cfg;
      if (start_rd) left <= cnt_cfg;
      else if (tick && st == S_RB && left != '0) left <= left - 1'b1;
      if (start_wr) begin
        dout_q <= tx_mem[tx_rp[AW-1:0]];
        tx_rp  <= tx_rp + 1'b1;
      end
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp[AW-1:0]] <= host_wdata;
    if (rx_push) rx_mem[rx_wp[AW-1:0]] <= bus_din;
  end

  assign bus_cs   = st == S_WA || st == S_RA;
  assign bus_wr   = st == S_WA || st == S_WB;
  assign bus_rd   = st == S_RA || st == S_RB;
  assign bus_req  = st != S_IDLE;
  assign bus_oe   = bus_wr;
  assign bus_dout = dout_q;

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      2'd0: begin
        host_rdata[0]          = rd_pend;
        host_rdata[1 +: CNT_W] = cnt_cfg;
        host_rdata[8 +: DIV_W] = div_cfg;
      end
      2'd2: host_rdata = rx_mem[rx_rp[AW-1:0]];
      2'd3: host_rdata[5:0] = {rd_pend, rx_empty, rx_full, tx_empty, tx_full, bus_req};
      default: host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pbm_ctrl_chk.sv
module pbm_ctrl_chk #(parameter int DW = 16) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_cs,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic          bus_req,
  input logic [DW-1:0] bus_dout,
  input logic          tx_empty,
  input logic          rd_pend
);
  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n) !(bus_wr && bus_rd));
  p_cs_in_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cs |-> (bus_req && (bus_wr || bus_rd)));
  p_dout_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_cs) |-> $stable(bus_dout));
  p_rd_wait_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd) |-> $past(tx_empty));
  p_rdbit_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_pend) |-> $past(bus_rd));
  p_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_wr || bus_rd));
endmodule

bind pbm_ctrl pbm_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_req(bus_req), .bus_dout(bus_dout), .tx_empty(tx_empty), .rd_pend(rd_pend)
);

// File: tb/pbm_ctrl_test.sv
module pbm_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] host_addr = 0;
  logic host_wr = 0, host_rd = 0;
  logic [15:0] host_wdata = 0, host_rdata, bus_dout, bus_din = 0;
  logic bus_cs, bus_wr, bus_rd, bus_req, bus_oe;

  pbm_ctrl uut (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  logic [15:0] wlog [128];
  int wcount = 0, rcount = 0, burst_wc = 0, last_wr_rc = 0;
  int req_len = 0, last_req_len = 0, hi_len = 0;
  int exp_div_wr = 0, exp_div_rd = 0;
  logic prev_cs = 0, prev_wr = 0, prev_rd = 0;
  logic [15:0] rise_dout = 0;

  function automatic logic [15:0] ctrlw(input int rd, input int cnt, input int dv);
    return 16'((dv << 8) | (cnt << 1) | rd);
  endfunction

  function automatic logic [15:0] slave_word(input int idx);
    return 16'hA000 + 16'(idx);
  endfunction

  always @(negedge clk) if (rst_n) begin
    if (bus_req) req_len++;
    else if (req_len != 0) begin last_req_len = req_len; req_len = 0; end
    if (bus_cs && !prev_cs) begin
      hi_len = 1;
      rise_dout = bus_dout;
      if (bus_wr) begin
        wlog[wcount % 128] = bus_dout; wcount++; last_wr_rc = rcount;
      end else if (bus_rd) begin
        if (!prev_rd) burst_wc = wcount;
        bus_din = slave_word(rcount); rcount++;
      end
    end else if (bus_cs) hi_len++;
    if (!bus_cs && prev_cs) begin
      chk(hi_len == (prev_wr ? exp_div_wr : exp_div_rd) + 1, "R3 cs high length",
          hi_len, (prev_wr ? exp_div_wr : exp_div_rd) + 1);
      if (prev_wr) chk(bus_dout == rise_dout, "R3 dout stable", bus_dout, rise_dout);
    end
    prev_cs = bus_cs; prev_wr = bus_wr; prev_rd = bus_rd;
  end

  task automatic hwrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic hread(input logic [1:0] a, input bit pop, output logic [15:0] d);
    @(negedge clk); host_addr = a; #1; d = host_rdata;
    if (pop) begin host_rd = 1; @(negedge clk); host_rd = 0; end
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    repeat (3) @(negedge clk);
    do hread(2'd3, 0, s); while (s[0] || !s[2] || s[5]);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
    end
    $finish;
  end

  initial begin
    logic [15:0] s, q[$];
    int base, n, d, rc0;
    void'($urandom(32'd41));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    hread(2'd3, 0, s);
    chk(s == 16'h0014, "R1 status", s, 16'h14);
    chk({bus_cs, bus_wr, bus_rd, bus_req} == 4'b0, "R1 strobes", {bus_cs, bus_wr, bus_rd, bus_req}, 0);

    // R3 R4 directed chain, div 0
    hwrite(2'd0, ctrlw(0, 0, 0)); exp_div_wr = 0;
    base = wcount;
    for (int i = 0; i < 3; i++) hwrite(2'd1, 16'h1100 + 16'(i));
    wait_idle();
    chk(last_req_len == 6, "R4 chain length", last_req_len, 6);
    for (int i = 0; i < 3; i++)
      chk(wlog[(base + i) % 128] == 16'h1100 + 16'(i), "R3 write order", wlog[(base + i) % 128], 16'h1100 + i);

    // R3 R4 random chains
    for (int r = 0; r < 4; r++) begin
      d = int'($urandom % 4); n = 1 + int'($urandom % 8);
      hwrite(2'd0, ctrlw(0, 0, d)); exp_div_wr = d;
      base = wcount; q.delete();
      for (int i = 0; i < n; i++) begin
        s = 16'($urandom); q.push_back(s); hwrite(2'd1, s);
      end
      wait_idle();
      chk(wcount - base == n, "R4 word count", wcount - base, n);
      chk(last_req_len == n * 2 * (d + 1), "R4 back-to-back", last_req_len, n * 2 * (d + 1));
      for (int i = 0; i < n; i++)
        chk(wlog[(base + i) % 128] == q[i], "R3 random order", wlog[(base + i) % 128], q[i]);
    end

    // R2 tx full drop, R11 busy
    hwrite(2'd0, ctrlw(0, 0, 15)); exp_div_wr = 15;
    base = wcount;
    for (int i = 0; i < 10; i++) hwrite(2'd1, 16'h2200 + 16'(i));
    hread(2'd3, 0, s);
    chk(s[1] == 1, "R2 tx full flag", s[1], 1);
    chk(s[0] == 1 && bus_req, "R11 busy during write", s[0], 1);
    wait_idle();
    chk(wcount - base == 9, "R2 dropped push", wcount - base, 9);
    for (int i = 0; i < 9; i++)
      chk(wlog[(base + i) % 128] == 16'h2200 + 16'(i), "R2 kept words", wlog[(base + i) % 128], 16'h2200 + i);

    // R5 R6 R8 read waits for tx drain
    hwrite(2'd0, ctrlw(0, 0, 1)); exp_div_wr = 1; exp_div_rd = 1;
    base = wcount; rc0 = rcount;
    for (int i = 0; i < 4; i++) hwrite(2'd1, 16'h3300 + 16'(i));
    hwrite(2'd0, ctrlw(1, 1, 1));
    hread(2'd0, 0, s);
    chk(s[0] == 1, "R8 pending reads 1", s[0], 1);
    wait_idle();
    chk(burst_wc == base + 4, "R5 burst after drain", burst_wc, base + 4);
    chk(rcount - rc0 == 2, "R6 burst length", rcount - rc0, 2);
    hread(2'd0, 0, s);
    chk(s[0] == 0, "R8 self clear", s[0], 0);
    for (int i = 0; i < 2; i++) begin
      hread(2'd2, 1, s);
      chk(s == slave_word(rc0 + i), "R6 rx data", s, slave_word(rc0 + i));
    end

    // R7 R9 writes deferred, config latched
    hwrite(2'd0, ctrlw(1, 3, 2)); exp_div_rd = 2; exp_div_wr = 0;
    rc0 = rcount; base = wcount;
    repeat (3) @(negedge clk);
    chk(bus_rd == 1, "R11 req during read", bus_rd, 1);
    hwrite(2'd1, 16'h4400);
    hwrite(2'd1, 16'h4401);
    hwrite(2'd0, ctrlw(0, 0, 0));
    hread(2'd0, 0, s);
    chk(s[0] == 1, "R8 write of 0 ignored", s[0], 1);
    wait_idle();
    chk(rcount - rc0 == 4, "R9 burst length kept", rcount - rc0, 4);
    chk(wcount - base == 2, "R7 deferred writes", wcount - base, 2);
    chk(last_wr_rc == rc0 + 4, "R7 writes after burst", last_wr_rc, rc0 + 4);
    for (int i = 0; i < 4; i++) begin
      hread(2'd2, 1, s);
      chk(s == slave_word(rc0 + i), "R6 rx order", s, slave_word(rc0 + i));
    end

    // R10 rx full drop and empty pop
    exp_div_rd = 0; rc0 = rcount;
    hwrite(2'd0, ctrlw(1, 7, 0)); wait_idle();
    hwrite(2'd0, ctrlw(1, 1, 0)); wait_idle();
    hread(2'd3, 0, s);
    chk(s[3] == 1, "R10 rx full flag", s[3], 1);
    for (int i = 0; i < 8; i++) begin
      hread(2'd2, 1, s);
      chk(s == slave_word(rc0 + i), "R10 rx kept", s, slave_word(rc0 + i));
    end
    hread(2'd2, 1, s);
    hread(2'd3, 0, s);
    chk(s[4] == 1 && s[3] == 0, "R10 empty after pop of empty", s[4], 1);
    hwrite(2'd0, ctrlw(1, 0, 0)); wait_idle();
    hread(2'd2, 1, s);
    chk(s == slave_word(rc0 + 10), "R10 next word after drop", s, slave_word(rc0 + 10));
    hread(2'd3, 0, s);
    chk(s == 16'h0014, "R11 idle status", s, 16'h14);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
    end
    $finish;
  end
endmodule